// File: doc/BRIEF.md
# DS1 Payload Mapper for a 32-Channel TDM Backplane

This block moves the 24 payload bytes of a DS1 (T1) frame across a serial time-division backplane in both directions. The backplane frame repeats at 8 kHz and holds 32 byte-wide channels. It is clocked at 4.096 MHz, which gives two clock cycles per data bit. An active-low frame pulse, one clock long, marks each frame boundary. The clock and frame pulse always come from outside the block.

On the transmit side, a 24-byte parallel buffer is captured at each frame boundary. Its bytes are then shifted out, most significant bit first, into the backplane channels chosen by the mapping. On the receive side, each mapped channel is sampled in the middle of every bit period. The completed 24-byte frame is presented on a parallel output at the next frame boundary.

There are two mappings. The spaced mapping leaves every fourth channel (0, 4, 8, ... 28) empty and uses the rest in ascending order. The grouped mapping fills channels 0 to 23 and leaves 24 to 31 empty. The transmit output is released to high impedance through its enable on every empty channel. The mapping select is only taken at a frame boundary, so no frame ever mixes the two schemes.

Top module: `ds1_bp_mapper`

## Requirements
- R1: While reset is low, `tx_oe` is 0 and `rx_payload` is all zeros. After reset and until the first frame pulse, `tx_oe` stays 0.
- R2: A clock edge that samples `fp_n` low sets the frame position to channel 0, bit 7, first clock. Each bit lasts 2 clocks and each channel 16 clocks, so one frame is 512 clocks. Bits go out MSB first, and `tx_sd`/`tx_oe` change only at the start of a bit period.
- R3: Spaced mode (`mode_sel`=0): DS1 slot n uses backplane channel 4*(n/3)+(n mod 3)+1. The slot's byte is `tx_payload[8n+7:8n]` on transmit and `rx_payload[8n+7:8n]` on receive.
- R4: Grouped mode (`mode_sel`=1): DS1 slot n uses backplane channel n, for n from 0 to 23. The byte fields are as in R3.
- R5: `tx_oe` is 1 for the whole of every mapped channel and 0 for the whole of every unmapped channel. While `tx_oe` is 0, `tx_sd` is 0.
- R6: Each receive bit is taken from `rx_sd` during the first clock of its two-clock period. `rx_payload` changes only at the edge that samples the frame pulse, and that edge loads the frame just completed.
- R7: `mode_sel` is captured only at the frame pulse edge. A change in the middle of a frame takes effect from the next frame.
- R8: `tx_payload` is captured only at the frame pulse edge. Changes during a frame do not alter the bits sent in that frame.
- R9: Data on `rx_sd` during unmapped channels has no effect on `rx_payload`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Backplane bit clock, two cycles per data bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_n | input | 1 | Active-low frame pulse, one clock spanning the boundary |
| mode_sel | input | 1 | Mapping select: 0 spaced, 1 grouped |
| rx_sd | input | 1 | Serial receive data from the backplane |
| tx_payload | input | 192 | 24 transmit bytes, slot n at bits 8n+7:8n |
| tx_sd | output | 1 | Serial transmit data to the backplane |
| tx_oe | output | 1 | Transmit drive enable, 0 means high impedance |
| rx_payload | output | 192 | 24 received bytes, slot n at bits 8n+7:8n |

## Verification
The hardest cases to reach are the frame boundary events. One is a mapping change or a new transmit buffer arriving in the middle of a frame. The other is a frame pulse arriving early, which must restart the counters without leaving any channel misaligned. The stimulus moves `mode_sel` and `tx_payload` at a different offset inside each frame of the vector table, then checks every bit period of that frame against the previous settings. A later directed sequence fires a frame pulse 137 clocks into a frame and checks the full frame that follows. Junk data is driven on the unmapped channels and the captured bytes are compared, which shows that gaps in the receive stream are skipped.

// File: rtl/ds1_bp_pkg.sv
package ds1_bp_pkg;

  typedef enum logic {
    MAP_SPACED  = 1'b0,
    MAP_GROUPED = 1'b1
  } map_mode_e;

  // Returns 1 when a backplane channel carries a DS1 slot.
  function automatic logic map_used(input int unsigned chan, input logic grouped,
                                    input int unsigned slots, input int unsigned group);
    if (grouped) return chan < slots;
    if ((chan % group) == 0) return 1'b0;
    return ((chan / group) * (group - 1) + (chan % group) - 1) < slots;
  endfunction

  // DS1 slot index carried by a backplane channel (only meaningful when used).
  function automatic int unsigned map_slot(input int unsigned chan, input logic grouped,
                                           input int unsigned group);
    if (grouped) return chan;
    if ((chan % group) == 0) return 0;
    return (chan / group) * (group - 1) + (chan % group) - 1;
  endfunction

endpackage

// File: rtl/ds1_bp_timing.sv
module ds1_bp_timing #(
  parameter int CHANNELS    = 32,
  parameter int BITS        = 8,
  parameter int CLK_PER_BIT = 2,
  localparam int CH_W = $clog2(CHANNELS),
  localparam int BT_W = $clog2(BITS),
  localparam int PH_W = $clog2(CLK_PER_BIT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fp_n,
  input  logic             mode_sel,
  output logic             aligned,
  output logic             frame_start,
  output logic             sample_now,
  output logic [PH_W-1:0]  phase,
  output logic [BT_W-1:0]  bitn,
  output logic [CH_W-1:0]  chan,
  output logic             mode_q
);
  localparam logic [PH_W-1:0] PH_LAST   = PH_W'(CLK_PER_BIT - 1);
  localparam logic [PH_W-1:0] PH_SAMPLE = PH_W'(CLK_PER_BIT / 2 - 1);
  localparam logic [BT_W-1:0] BIT_MSB   = BT_W'(BITS - 1);
  localparam logic [CH_W-1:0] CH_LAST   = CH_W'(CHANNELS - 1);

  assign frame_start = !fp_n;
  assign sample_now  = aligned && fp_n && (phase == PH_SAMPLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= '0;
      bitn    <= BIT_MSB;
      chan    <= '0;
      aligned <= 1'b0;
      mode_q  <= ds1_bp_pkg::MAP_SPACED;
    end else if (frame_start) begin
      phase   <= '0;
      bitn    <= BIT_MSB;
      chan    <= '0;
      aligned <= 1'b1;
      mode_q  <= mode_sel;
    end else if (phase == PH_LAST) begin
      phase <= '0;
      if (bitn == '0) begin
        bitn <= BIT_MSB;
        chan <= (chan == CH_LAST) ? '0 : chan + 1'b1;
      end else begin
        bitn <= bitn - 1'b1;
      end
    end else begin
      phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/ds1_bp_tx.sv
module ds1_bp_tx #(
  parameter int SLOTS = 24,
  parameter int BITS  = 8,
  localparam int SL_W = $clog2(SLOTS),
  localparam int BT_W = $clog2(BITS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_start,
  input  logic                  slot_active,
  input  logic [SL_W-1:0]       slot_idx,
  input  logic [BT_W-1:0]       bitn,
  input  logic [SLOTS*BITS-1:0] tx_payload,
  output logic                  tx_sd,
  output logic                  tx_oe
);
  logic [SLOTS-1:0][BITS-1:0] shadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           shadow <= '0;
    else if (frame_start) shadow <= tx_payload;
  end

  assign tx_oe = slot_active;
  assign tx_sd = slot_active ? shadow[slot_idx][bitn] : 1'b0;
endmodule

// File: rtl/ds1_bp_rx.sv
module ds1_bp_rx #(
  parameter int SLOTS = 24,
  parameter int BITS  = 8,
  localparam int SL_W = $clog2(SLOTS),
  localparam int BT_W = $clog2(BITS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_start,
  input  logic                  sample_now,
  input  logic                  slot_active,
  input  logic [SL_W-1:0]       slot_idx,
  input  logic [BT_W-1:0]       bitn,
  input  logic                  rx_sd,
  output logic [SLOTS*BITS-1:0] rx_payload
);
  logic [SLOTS-1:0][BITS-1:0] work;
  logic [SLOTS-1:0][BITS-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work <= '0;
      held <= '0;
    end else begin
      if (sample_now && slot_active) work[slot_idx][bitn] <= rx_sd;
      if (frame_start) held <= work;
    end
  end

  assign rx_payload = held;
endmodule

// File: rtl/ds1_bp_mapper.sv
module ds1_bp_mapper #(
  parameter int CHANNELS    = 32,
  parameter int SLOTS       = 24,
  parameter int BITS        = 8,
  parameter int CLK_PER_BIT = 2,
  parameter int GROUP       = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fp_n,
  input  logic                  mode_sel,
  input  logic                  rx_sd,
  input  logic [SLOTS*BITS-1:0] tx_payload,
  output logic                  tx_sd,
  output logic                  tx_oe,
  output logic [SLOTS*BITS-1:0] rx_payload
);
  localparam int CH_W = $clog2(CHANNELS);
  localparam int BT_W = $clog2(BITS);
  localparam int PH_W = $clog2(CLK_PER_BIT);
  localparam int SL_W = $clog2(SLOTS);

  // Named internal events, visible to the bound checker.
  logic            aligned;
  logic            frame_start;
  logic            sample_now;
  logic [PH_W-1:0] phase;
  logic [BT_W-1:0] bitn;
  logic [CH_W-1:0] chan;
  logic            mode_q;
  logic            slot_used;
  logic            slot_active;
  logic [SL_W-1:0] slot_idx;

  ds1_bp_timing #(
    .CHANNELS(CHANNELS), .BITS(BITS), .CLK_PER_BIT(CLK_PER_BIT)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .fp_n(fp_n), .mode_sel(mode_sel),
    .aligned(aligned), .frame_start(frame_start), .sample_now(sample_now),
    .phase(phase), .bitn(bitn), .chan(chan), .mode_q(mode_q)
  );

  always_comb begin
    slot_used = ds1_bp_pkg::map_used(int'(chan), mode_q, SLOTS, GROUP);
    slot_idx  = SL_W'(ds1_bp_pkg::map_slot(int'(chan), mode_q, GROUP));
  end

  assign slot_active = aligned && slot_used;

  ds1_bp_tx #(.SLOTS(SLOTS), .BITS(BITS)) u_tx (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .slot_active(slot_active), .slot_idx(slot_idx), .bitn(bitn),
    .tx_payload(tx_payload), .tx_sd(tx_sd), .tx_oe(tx_oe)
  );

  ds1_bp_rx #(.SLOTS(SLOTS), .BITS(BITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .sample_now(sample_now), .slot_active(slot_active), .slot_idx(slot_idx),
    .bitn(bitn), .rx_sd(rx_sd), .rx_payload(rx_payload)
  );
endmodule

// File: rtl/ds1_bp_mapper_chk.sv
module ds1_bp_mapper_chk #(
  parameter int CHANNELS    = 32,
  parameter int SLOTS       = 24,
  parameter int BITS        = 8,
  parameter int CLK_PER_BIT = 2,
  parameter int GROUP       = 4,
  localparam int CH_W = $clog2(CHANNELS),
  localparam int BT_W = $clog2(BITS),
  localparam int PH_W = $clog2(CLK_PER_BIT)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  fp_n,
  input logic                  tx_sd,
  input logic                  tx_oe,
  input logic [SLOTS*BITS-1:0] rx_payload,
  input logic                  aligned,
  input logic                  mode_q,
  input logic [CH_W-1:0]       chan,
  input logic [BT_W-1:0]       bitn,
  input logic [PH_W-1:0]       phase
);
  localparam logic [CH_W-1:0] GRP_MASK = CH_W'(GROUP - 1);
  localparam logic [CH_W-1:0] CH_SLOTS = CH_W'(SLOTS);

  a_r1_unaligned_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !aligned |-> !tx_oe);

  a_r2_realign: assert property (@(posedge clk) disable iff (!rst_n)
    !fp_n |=> (chan == '0 && bitn == BT_W'(BITS - 1) && phase == '0));

  a_r2_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != '0) |-> ($stable(tx_sd) && $stable(tx_oe)));

  a_r5_spaced_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && (chan & GRP_MASK) == '0) |-> !tx_oe);

  a_r5_grouped_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && chan >= CH_SLOTS) |-> !tx_oe);

  a_r5_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_oe |-> !tx_sd);

  a_r6_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fp_n |=> $stable(rx_payload));

  a_r7_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fp_n |=> $stable(mode_q));
endmodule

bind ds1_bp_mapper ds1_bp_mapper_chk #(
  .CHANNELS(CHANNELS), .SLOTS(SLOTS), .BITS(BITS),
  .CLK_PER_BIT(CLK_PER_BIT), .GROUP(GROUP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fp_n(fp_n), .tx_sd(tx_sd), .tx_oe(tx_oe),
  .rx_payload(rx_payload), .aligned(aligned), .mode_q(mode_q),
  .chan(chan), .bitn(bitn), .phase(phase)
);

// File: tb/ds1_bp_mapper_test.sv
module ds1_bp_mapper_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fp_n = 1'b1;
  logic         mode_sel = 1'b0;
  logic         rx_sd = 1'b0;
  logic [191:0] tx_payload = '0;
  logic         tx_sd;
  logic         tx_oe;
  logic [191:0] rx_payload;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic         cur_mode;
  logic [191:0] cur_tx;
  logic [191:0] prev_rx;

  // Each entry: {next mode, seed}
  localparam logic [8:0] VEC [0:5] = '{
    {1'b0, 8'h11}, {1'b0, 8'h5a}, {1'b1, 8'h23},
    {1'b1, 8'hc4}, {1'b0, 8'h97}, {1'b1, 8'h3e}
  };

  always #2 clk = ~clk;

  ds1_bp_mapper uut (
    .clk(clk), .rst_n(rst_n), .fp_n(fp_n), .mode_sel(mode_sel), .rx_sd(rx_sd),
    .tx_payload(tx_payload), .tx_sd(tx_sd), .tx_oe(tx_oe), .rx_payload(rx_payload)
  );

  function automatic logic [191:0] make_bytes(input logic [7:0] seed, input logic [7:0] salt);
    logic [191:0] v;
    for (int s = 0; s < 24; s++) v[s*8 +: 8] = 8'(s * 37 + seed * 11 + salt) ^ seed;
    return v;
  endfunction

  // Bench view of the map: which slot a channel holds, -1 for none.
  function automatic int chan_slot(input int ch, input logic grouped);
    if (grouped) return (ch < 24) ? ch : -1;
    if (ch % 4 == 0) return -1;
    return ch - ch / 4 - 1;
  endfunction

  task automatic check(input bit ok, input string req, input logic [191:0] act,
                       input logic [191:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one frame starting in position 0; closes it with a frame pulse.
  task automatic run_frame(input logic nxt_mode, input logic [191:0] nxt_tx,
                           input logic [191:0] rxd, input logic [7:0] junk,
                           input int change_at);
    int data_err = 0;
    int oe_err = 0;
    for (int c = 0; c < 512; c++) begin
      int ch = c / 16;
      int b = 7 - (c % 16) / 2;
      int sl = chan_slot(ch, cur_mode);
      if (sl >= 0) begin
        if (tx_oe !== 1'b1) oe_err++;
        if (tx_sd !== cur_tx[sl*8 + b]) data_err++;
        rx_sd = rxd[sl*8 + b];
      end else begin
        if (tx_oe !== 1'b0 || tx_sd !== 1'b0) oe_err++;
        rx_sd = junk[b] ^ ch[0];
      end
      if (c == 256) check(rx_payload == prev_rx, "R6 hold", rx_payload, prev_rx);
      if (c == change_at) begin
        mode_sel   = nxt_mode;
        tx_payload = nxt_tx;
      end
      fp_n = (c == 511) ? 1'b0 : 1'b1;
      @(negedge clk);
    end
    fp_n = 1'b1;
    check(data_err == 0, cur_mode ? "R4 R2 R7 R8 tx" : "R3 R2 R7 R8 tx",
          192'(data_err), 192'd0);
    check(oe_err == 0, "R5 oe", 192'(oe_err), 192'd0);
    check(rx_payload == rxd, cur_mode ? "R4 R6 R9 rx" : "R3 R6 R9 rx", rx_payload, rxd);
    prev_rx  = rxd;
    cur_mode = nxt_mode;
    cur_tx   = nxt_tx;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seen_oe;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(tx_oe == 1'b0, "R1 reset oe", 192'(tx_oe), 192'd0);
    check(rx_payload == '0, "R1 reset rx", rx_payload, 192'd0);
    rst_n = 1'b1;
    seen_oe = 0;
    for (int i = 0; i < 700; i++) begin
      rx_sd = i[3];
      @(negedge clk);
      if (tx_oe) seen_oe++;
    end
    check(seen_oe == 0, "R1 unaligned oe", 192'(seen_oe), 192'd0);

    // First alignment pulse at an arbitrary offset.
    mode_sel   = 1'b0;
    tx_payload = make_bytes(8'h01, 8'h07);
    fp_n = 1'b0;
    @(negedge clk);
    fp_n = 1'b1;
    cur_mode = 1'b0;
    cur_tx   = tx_payload;
    prev_rx  = '0;

    // Vector table walk: mode and buffer change mid-frame.
    for (int v = 0; v < 6; v++) begin
      run_frame(VEC[v][8], make_bytes(VEC[v][7:0], 8'h2b),
                make_bytes(VEC[v][7:0] ^ 8'hff, 8'h61), VEC[v][7:0] + 8'h40,
                40 + v * 83);
    end

    // R9: same receive bytes, opposite junk on the gaps.
    run_frame(1'b0, make_bytes(8'h77, 8'h01), make_bytes(8'h5c, 8'h0d), 8'h00, 3);
    run_frame(1'b0, make_bytes(8'h78, 8'h02), make_bytes(8'h5c, 8'h0d), 8'hff, 9);

    // R2: early frame pulse 137 clocks into a frame re-aligns the counters.
    for (int c = 0; c < 137; c++) begin
      rx_sd = 1'b0;
      @(negedge clk);
    end
    fp_n = 1'b0;
    @(negedge clk);
    fp_n = 1'b1;
    // The early pulse loaded a partial frame; take that as the held value.
    prev_rx = rx_payload;
    run_frame(1'b1, make_bytes(8'h9a, 8'h33), make_bytes(8'h2e, 8'h44), 8'h5a, 200);
    run_frame(1'b1, make_bytes(8'h9b, 8'h34), make_bytes(8'h2f, 8'h45), 8'ha5, 500);

    // R1: reset in mid-operation returns to the idle state.
    repeat (50) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(tx_oe == 1'b0, "R1 re-reset oe", 192'(tx_oe), 192'd0);
    check(rx_payload == '0, "R1 re-reset rx", rx_payload, 192'd0);
    rst_n = 1'b1;
    seen_oe = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (tx_oe) seen_oe++;
    end
    check(seen_oe == 0, "R1 post-reset oe", 192'(seen_oe), 192'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule